// File: doc/BRIEF.md
# Multi-Port Pin Bank Controller with Edge Interrupts

This block is a register-mapped general-purpose pin controller. It is organised as up to seven banks of eight pins, and it sits behind a plain 32-bit register bus. Software sets the drive style of each pin through a 2-bit mode field. Four styles are available: input only, actively driven both ways, low-side-only (open drain) and high-side-only (open source). Software also sets the output level, the pull-up disable and an edge polarity for each pin. The block turns these settings into output value, output enable, mode and pull-up signals for the pad ring.

Pad inputs pass through a two-flop synchroniser. A control bit picks whether the data-in register and the edge detector see the one-flop sample or the two-flop sample. Each pin detects a single edge polarity, chosen per pin. A detected edge sets a sticky event bit. Software clears an event bit by writing a one to it. A force register lets a test set event bits directly. Each bank drives its own interrupt line, which is the OR of its enabled event bits.

Top module: `pin_bank_top`

## Requirements
- R1: After reset, every bank register reads 0. All pins are inputs with padOe low. pullEn is all ones. Every portIrq is low.
- R2: Bank N begins at byte address N*0x30. Its registers sit at these offsets: 0x04 pin input (read only), 0x08 output level, 0x0C mode (16 bits), 0x10 pull-up disable, 0x14 event, 0x18 interrupt enable, 0x1C force, 0x20 edge polarity. Every 8-bit register uses data bits [7:0], and bit k belongs to pin k of the bank. Any other offset, and any bank at or above NUM_PORTS, reads 0 and ignores writes.
- R3: The control register sits at address 0x00. Bit 0 enables edge detection and bit 1 selects the two-flop input path; both are writable. Bits [8:2] read VERSION_ID and bits [15:9] read NUM_PORTS; these fields are read only.
- R4: Pin k uses mode bits [2k+1:2k]. Mode 0 gives padOe=0 and padOut=0. Mode 1 gives padOe=1 and padOut equal to the level bit. Mode 2 gives padOut=0 and padOe set only when the level bit is 0. Mode 3 gives padOut=1 and padOe set only when the level bit is 1. padMode carries the mode field.
- R5: A pull-up disable bit of 1 turns the pin's pullEn off. A 0 turns it on.
- R6: The pin input register shows a pad change 1 clock after it happens when control bit 1 is 0, and 2 clocks after when control bit 1 is 1.
- R7: An edge polarity bit of 1 latches rising edges only. A 0 latches falling edges only.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R9: Writing 1 to a force bit sets that event bit, even while detection is disabled. Writing 0 does nothing. The force register reads 0.
- R10: portIrq[N] is the OR over bank N's pins of event AND interrupt enable.
- R11: While control bit 0 is 0, pad edges latch no events. Setting the bit again produces no event for transitions that happened while it was 0.
- R12: When an edge is detected in the same cycle as a clearing write to its event bit, the event bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| padIn | input | 8*NUM_PORTS | Raw pad input levels |
| padOut | output | 8*NUM_PORTS | Output level for each pin |
| padOe | output | 8*NUM_PORTS | Output enable for each pin |
| padMode | output | 16*NUM_PORTS | Drive mode field for each pin |
| pullEn | output | 8*NUM_PORTS | Pull-up enable for each pin |
| portIrq | output | NUM_PORTS | Interrupt line for each bank |

## Verification
Two actions can land on the same event bit in one cycle: a pad edge being latched and a software write-one-to-clear. The bench raises a pad one clock before a clearing write, using the one-flop input path. This timing places the detection and the clearing write on the same rising edge. It then reads the event register and expects the bit still set. A second clearing write on its own must take the bit to zero.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int MAX_PORTS     = 7;
  localparam int PORT_STRIDE   = 48;

  typedef enum logic [3:0] {
    RK_NONE, RK_CTRL, RK_DIN, RK_DOUT, RK_CFG, RK_PULL,
    RK_EVT, RK_IEN, RK_FORCE, RK_EDGE
  } regKind_e;

  typedef struct packed {
    logic [2:0] portIdx;
    regKind_e   kind;
    logic       wrStb;
  } busStrobe_t;
endpackage

// File: rtl/pbank_ctrl.sv
module pbank_ctrl
  import pbank_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(PORT_STRIDE);

  logic [ADDR_W-1:0] portNum;
  logic [ADDR_W-1:0] offs;
  regKind_e          kind;

  always_comb begin
    portNum = busAddr / STRIDE_A;
    offs    = busAddr - portNum * STRIDE_A;
    case (offs)
      ADDR_W'(8'h00): kind = (portNum == '0) ? RK_CTRL : RK_NONE;
      ADDR_W'(8'h04): kind = RK_DIN;
      ADDR_W'(8'h08): kind = RK_DOUT;
      ADDR_W'(8'h0C): kind = RK_CFG;
      ADDR_W'(8'h10): kind = RK_PULL;
      ADDR_W'(8'h14): kind = RK_EVT;
      ADDR_W'(8'h18): kind = RK_IEN;
      ADDR_W'(8'h1C): kind = RK_FORCE;
      ADDR_W'(8'h20): kind = RK_EDGE;
      default:        kind = RK_NONE;
    endcase
    if (portNum >= ADDR_W'(NUM_PORTS)) kind = RK_NONE;
    strobe.portIdx = portNum[2:0];
    strobe.kind    = kind;
    strobe.wrStb   = busWe && (kind != RK_NONE) && (kind != RK_DIN);
  end
endmodule

// File: rtl/pbank_datapath.sv
module pbank_datapath
  import pbank_pkg::*;
#(
  parameter int         NUM_PORTS  = 7,
  parameter logic [6:0] VERSION_ID = 7'd3,
  localparam int        NPINS      = NUM_PORTS * PINS_PER_PORT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobe_t             strobe,
  input  logic [31:0]            busWdata,
  input  logic [NPINS-1:0]       padIn,
  output logic [31:0]            busRdata,
  output logic [NPINS-1:0]       padOut,
  output logic [NPINS-1:0]       padOe,
  output logic [2*NPINS-1:0]     padMode,
  output logic [NPINS-1:0]       pullEn,
  output logic [NUM_PORTS-1:0]   portIrq
);
  logic [NUM_PORTS-1:0][7:0]  doutR, pullDisR, ienR, edgeR, evtR;
  logic [NUM_PORTS-1:0][15:0] cfgR;
  logic                       ctrlEn, ctrlSync;
  logic [NPINS-1:0]           sync1, sync2, prevS, sampled;
  logic                       unusedHi;

  assign unusedHi = ^busWdata[31:16];
  assign sampled  = ctrlSync ? sync2 : sync1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
      prevS <= '0;
    end else begin
      sync1 <= padIn;
      sync2 <= sync1;
      prevS <= sampled;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      ctrlSync <= 1'b0;
    end else if (strobe.wrStb && strobe.kind == RK_CTRL) begin
      ctrlEn   <= busWdata[0];
      ctrlSync <= busWdata[1];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic       hit;
    logic [7:0] curS, oldS, detBits, clrMask, setMask;

    assign hit     = strobe.wrStb && (strobe.portIdx == 3'(p));
    assign curS    = sampled[p*8 +: 8];
    assign oldS    = prevS[p*8 +: 8];
    assign detBits = ctrlEn ? ((edgeR[p] & curS & ~oldS) | (~edgeR[p] & ~curS & oldS)) : 8'h00;
    assign clrMask = (hit && strobe.kind == RK_EVT)   ? busWdata[7:0] : 8'h00;
    assign setMask = (hit && strobe.kind == RK_FORCE) ? busWdata[7:0] : 8'h00;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        doutR[p]    <= '0;
        pullDisR[p] <= '0;
        ienR[p]     <= '0;
        edgeR[p]    <= '0;
        cfgR[p]     <= '0;
        evtR[p]     <= '0;
      end else begin
        if (hit) begin
          case (strobe.kind)
            RK_DOUT: doutR[p]    <= busWdata[7:0];
            RK_PULL: pullDisR[p] <= busWdata[7:0];
            RK_IEN:  ienR[p]     <= busWdata[7:0];
            RK_EDGE: edgeR[p]    <= busWdata[7:0];
            RK_CFG:  cfgR[p]     <= busWdata[15:0];
            default: ;
          endcase
        end
        evtR[p] <= (evtR[p] & ~clrMask) | detBits | setMask;
      end
    end

    assign portIrq[p]        = |(evtR[p] & ienR[p]);
    assign pullEn[p*8 +: 8]  = ~pullDisR[p];
    assign padMode[p*16 +: 16] = cfgR[p];

    for (genvar k = 0; k < PINS_PER_PORT; k++) begin : g_pin
      logic [1:0] mode;
      logic       lvl;
      assign mode = cfgR[p][2*k +: 2];
      assign lvl  = doutR[p][k];
      always_comb begin
        case (mode)
          2'd1:    begin padOe[p*8+k] = 1'b1; padOut[p*8+k] = lvl;  end
          2'd2:    begin padOe[p*8+k] = ~lvl; padOut[p*8+k] = 1'b0; end
          2'd3:    begin padOe[p*8+k] = lvl;  padOut[p*8+k] = 1'b1; end
          default: begin padOe[p*8+k] = 1'b0; padOut[p*8+k] = 1'b0; end
        endcase
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobe.kind == RK_CTRL) begin
      busRdata = {16'h0, 7'(NUM_PORTS), VERSION_ID, ctrlSync, ctrlEn};
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobe.portIdx == 3'(p)) begin
          case (strobe.kind)
            RK_DIN:  busRdata = {24'h0, sampled[p*8 +: 8]};
            RK_DOUT: busRdata = {24'h0, doutR[p]};
            RK_CFG:  busRdata = {16'h0, cfgR[p]};
            RK_PULL: busRdata = {24'h0, pullDisR[p]};
            RK_EVT:  busRdata = {24'h0, evtR[p]};
            RK_IEN:  busRdata = {24'h0, ienR[p]};
            RK_EDGE: busRdata = {24'h0, edgeR[p]};
            default: busRdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pin_bank_top.sv
module pin_bank_top
  import pbank_pkg::*;
#(
  parameter int         NUM_PORTS  = 7,
  parameter int         ADDR_W     = 12,
  parameter logic [6:0] VERSION_ID = 7'd3,
  localparam int        NPINS      = NUM_PORTS * PINS_PER_PORT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NPINS-1:0]     padIn,
  output logic [NPINS-1:0]     padOut,
  output logic [NPINS-1:0]     padOe,
  output logic [2*NPINS-1:0]   padMode,
  output logic [NPINS-1:0]     pullEn,
  output logic [NUM_PORTS-1:0] portIrq
);
  busStrobe_t strobe;

  pbank_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  pbank_datapath #(.NUM_PORTS(NUM_PORTS), .VERSION_ID(VERSION_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .padIn(padIn), .busRdata(busRdata), .padOut(padOut), .padOe(padOe),
    .padMode(padMode), .pullEn(pullEn), .portIrq(portIrq)
  );
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int         NUM_PORTS  = 7,
  parameter int         ADDR_W     = 12,
  parameter logic [6:0] VERSION_ID = 7'd3,
  localparam int        NPINS      = NUM_PORTS * 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic [NPINS-1:0]     padOut,
  input logic [NPINS-1:0]     padOe,
  input logic [2*NPINS-1:0]   padMode,
  input logic [NUM_PORTS-1:0] portIrq
);
  assert_ctrl_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == '0) |-> (busRdata[15:2] == {7'(NUM_PORTS), VERSION_ID}));

  for (genvar i = 0; i < NPINS; i++) begin : g_pinchk
    assert_input_no_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
      (padMode[2*i +: 2] == 2'd0) |-> !padOe[i]);
    assert_drain_never_high_R4: assert property (@(posedge clk) disable iff (!rstN)
      (padMode[2*i +: 2] == 2'd2 && padOe[i]) |-> !padOut[i]);
    assert_source_never_low_R4: assert property (@(posedge clk) disable iff (!rstN)
      (padMode[2*i +: 2] == 2'd3 && padOe[i]) |-> padOut[i]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portchk
    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == ADDR_W'(p*48 + 24) && busWdata[7:0] == 8'h00) |=> !portIrq[p]);
  end
endmodule

bind pin_bank_top pin_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .VERSION_ID(VERSION_ID)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .padOut(padOut),
  .padOe(padOe), .padMode(padMode), .portIrq(portIrq)
);

// File: tb/pin_bank_top_tb.sv
module pin_bank_top_tb;
  localparam int NP  = 3;
  localparam int NPP = NP * 8;
  localparam int AW  = 12;
  localparam logic [6:0] VER = 7'd3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic            busWe = 1'b0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic [NPP-1:0]  padIn = '0;
  logic [NPP-1:0]  padOut, padOe, pullEn;
  logic [2*NPP-1:0] padMode;
  logic [NP-1:0]   portIrq;
  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  pin_bank_top #(.NUM_PORTS(NP), .ADDR_W(AW), .VERSION_ID(VER)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padMode(padMode),
    .pullEn(pullEn), .portIrq(portIrq)
  );

  function automatic logic [AW-1:0] ra(int p, int off);
    return AW'(p * 48 + off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ctrlExp;
    ctrlExp = {16'h0, 7'(NP), VER, 2'b00};
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    for (int p = 0; p < NP; p++)
      for (int off = 4; off <= 32; off += 4) begin
        rd(ra(p, off), rv);
        chk($sformatf("R1 reset p%0d off%0h", p, off), rv, 0);
      end
    chk("R1 padOe", 32'(padOe), 0);
    chk("R1 pullEn", 32'(pullEn), 32'(24'hFFFFFF));
    chk("R1 irq", 32'(portIrq), 0);
    rd(0, rv); chk("R3 ctrl reset", rv, ctrlExp);

    // R3: control writes, read-only fields kept
    wr(0, 32'hFFFF_FFFF); rd(0, rv); chk("R3 ctrl all ones", rv, ctrlExp | 3);
    wr(0, 32'h0000_0001); rd(0, rv); chk("R3 ctrl en only", rv, ctrlExp | 1);

    // R2: register map sweep
    for (int p = 0; p < NP; p++) begin
      logic [31:0] w;
      w = 32'hA5C3_0000 | 32'((p * 37 + 5) * 257);
      wr(ra(p, 8), w); wr(ra(p, 12), w); wr(ra(p, 16), w);
      wr(ra(p, 24), w); wr(ra(p, 32), w);
    end
    for (int p = 0; p < NP; p++) begin
      logic [31:0] w;
      w = 32'hA5C3_0000 | 32'((p * 37 + 5) * 257);
      rd(ra(p, 8),  rv); chk("R2 dout",  rv, {24'h0, w[7:0]});
      rd(ra(p, 12), rv); chk("R2 cfg",   rv, {16'h0, w[15:0]});
      rd(ra(p, 16), rv); chk("R2 pull",  rv, {24'h0, w[7:0]});
      rd(ra(p, 24), rv); chk("R2 ien",   rv, {24'h0, w[7:0]});
      rd(ra(p, 32), rv); chk("R2 edge",  rv, {24'h0, w[7:0]});
      rd(ra(p, 28), rv); chk("R9 force reads 0", rv, 0);
    end
    for (int p = 0; p < NP; p++) begin
      wr(ra(p, 8), 0); wr(ra(p, 12), 0); wr(ra(p, 16), 0);
      wr(ra(p, 24), 0); wr(ra(p, 32), 0);
    end
    wr(ra(0, 36), 32'hFF); wr(ra(NP, 8), 32'hFF);
    rd(ra(0, 36), rv); chk("R2 unmapped 0x24", rv, 0);
    rd(ra(0, 44), rv); chk("R2 unmapped 0x2C", rv, 0);
    rd(ra(1, 0), rv);  chk("R2 bank1 base", rv, 0);
    rd(ra(NP, 8), rv); chk("R2 absent bank", rv, 0);
    rd(ra(0, 8), rv);  chk("R2 no alias write", rv, 0);

    // R4: exhaustive levels against modes 0..3 across pins
    wr(ra(0, 12), 32'h0000_E4E4);
    chk("R4 padMode", 32'(padMode[15:0]), 32'hE4E4);
    for (int d = 0; d < 256; d++) begin
      logic [7:0] eo, ee;
      wr(ra(0, 8), 32'(d));
      for (int k = 0; k < 8; k++) begin
        case (k % 4)
          1: begin ee[k] = 1'b1; eo[k] = d[k]; end
          2: begin ee[k] = ~d[k]; eo[k] = 1'b0; end
          3: begin ee[k] = d[k]; eo[k] = 1'b1; end
          default: begin ee[k] = 1'b0; eo[k] = 1'b0; end
        endcase
      end
      chk($sformatf("R4 oe d=%0d", d), 32'(padOe[7:0]), 32'(ee));
      chk($sformatf("R4 out d=%0d", d), 32'(padOut[7:0]), 32'(eo));
    end
    wr(ra(0, 12), 0); wr(ra(0, 8), 0);

    // R5: pull-up disable polarity
    wr(ra(0, 16), 32'h5A);
    chk("R5 pullEn", 32'(pullEn), 32'(24'hFFFFA5));
    wr(ra(0, 16), 0);

    // R6: input latency, one-flop path (ctrl=1)
    padIn[8] = 1'b1; idle(1);
    rd(ra(1, 4), rv); chk("R6 one-flop after 1", rv, 32'h01);
    padIn[8] = 1'b0; idle(3);
    wr(0, 32'h3);
    padIn[8] = 1'b1; idle(1);
    rd(ra(1, 4), rv); chk("R6 two-flop after 1", rv, 32'h00);
    idle(1);
    rd(ra(1, 4), rv); chk("R6 two-flop after 2", rv, 32'h01);
    padIn[8] = 1'b0; idle(4);
    wr(0, 32'h1);
    wr(ra(1, 20), 32'hFF);

    // R7: edge polarity per pin
    wr(ra(1, 32), 32'h0F);
    padIn[15:8] = 8'hFF; idle(4);
    rd(ra(1, 20), rv); chk("R7 rising only", rv, 32'h0F);
    wr(ra(1, 20), 32'hFF);
    rd(ra(1, 20), rv); chk("R8 clear all", rv, 0);
    padIn[15:8] = 8'h00; idle(4);
    rd(ra(1, 20), rv); chk("R7 falling only", rv, 32'hF0);
    wr(ra(1, 20), 32'hFF);

    // R8/R9: write-one-to-clear and force
    wr(ra(2, 28), 32'hFF);
    rd(ra(2, 20), rv); chk("R9 force sets", rv, 32'hFF);
    wr(ra(2, 20), 32'h0F);
    rd(ra(2, 20), rv); chk("R8 partial clear", rv, 32'hF0);
    wr(ra(2, 20), 32'h00);
    rd(ra(2, 20), rv); chk("R8 zero write keeps", rv, 32'hF0);
    wr(ra(2, 28), 32'h00);
    rd(ra(2, 20), rv); chk("R9 zero force keeps", rv, 32'hF0);

    // R10: interrupt combine
    wr(ra(2, 24), 32'h0F);
    chk("R10 disjoint enable", 32'(portIrq), 0);
    wr(ra(2, 24), 32'h10);
    chk("R10 one enabled", 32'(portIrq), 32'b100);
    wr(ra(2, 20), 32'h10);
    chk("R10 after clear", 32'(portIrq), 0);
    wr(ra(2, 24), 0);
    wr(ra(2, 20), 32'hFF);

    // R11: detection disabled
    wr(0, 32'h0);
    wr(ra(2, 32), 32'hFF);
    padIn[23:16] = 8'hFF; idle(4);
    rd(ra(2, 20), rv); chk("R11 no event when off", rv, 0);
    wr(ra(2, 28), 32'h81);
    rd(ra(2, 20), rv); chk("R11 force while off", rv, 32'h81);
    wr(0, 32'h1); idle(4);
    rd(ra(2, 20), rv); chk("R11 no spurious on enable", rv, 32'h81);
    wr(ra(2, 20), 32'hFF);

    // R12: edge and clear in the same cycle
    wr(ra(0, 32), 32'h01);
    idle(4);
    wr(ra(0, 20), 32'hFF);
    wr(ra(0, 28), 32'h01);
    padIn[0] = 1'b1;
    idle(1);
    wr(ra(0, 20), 32'h01);
    rd(ra(0, 20), rv); chk("R12 set wins over clear", rv, 32'h01);
    wr(ra(0, 20), 32'h01);
    rd(ra(0, 20), rv); chk("R12 lone clear", rv, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule